// File: doc/BRIEF.md
# Dual-Source Watchdog Timer

This block watches for software that has stopped servicing it. A down counter steps once per tick from one of two prescaled sources. One is the system clock divided by 16 or 128. The other is an external slow-oscillator enable divided by 1, 2, 4 or 8. If software does not pulse `refresh` before the counter passes zero, the block raises an underflow event. That event is either a one-cycle interrupt pulse or a latched reset request, chosen by a sticky action bit.

The system-clock path gives a span of 2^BUS_SPAN_W ticks and can be frozen by a halt indication. The oscillator path gives a shorter span of 2^OSC_SPAN_W ticks and ignores the halt. A start-mode input, sampled while reset is held, picks the power-up state: the block either counts at once or waits for the first refresh.

The controller has three states. `WD_IDLE` is stopped and waits for a first refresh. `WD_RUN` counts. `WD_TRIPPED` holds the reset request. There are three transitions:
- System reset enters `WD_IDLE` when `start_mode`=1 and `WD_RUN` when it is 0.
- `WD_IDLE` goes to `WD_RUN` on `refresh`.
- `WD_RUN` goes to `WD_TRIPPED` on an underflow while the action bit selects reset.

`WD_TRIPPED` is left only by system reset.

Top module: `wdt_core`

## Requirements
- R1: During synchronous reset (`rst_n`=0), `count` holds the reload value of the source selected by `src_osc`, and `irq` and `rst_req` are 0. With `start_mode`=0, counting begins on the first clock edge after reset is released.
- R2: The system-clock prescaler keeps a phase that counts modulo 128. The phase advances on each clock edge while the state is `WD_RUN`, `src_osc`=0 and `freeze`=0. It yields a tick on every advance that completes a multiple of the divisor: 16 when `bus_div_sel`=0, 128 when it is 1. An interrupt-to-interrupt period is therefore divisor × 2^BUS_SPAN_W clocks.
- R3: The oscillator prescaler keeps a phase that counts `osc_tick` pulses modulo 8 while in `WD_RUN`. It yields a tick on every pulse that completes a multiple of 2^`osc_div_sel`. A period is therefore 2^`osc_div_sel` × 2^OSC_SPAN_W oscillator pulses.
- R4: The counter drops by exactly one per tick of the selected source. Its reload value is the all-ones value of the selected span: 2^BUS_SPAN_W−1 when `src_osc`=0, 2^OSC_SPAN_W−1 when `src_osc`=1. A tick that finds the counter at zero is an underflow and reloads it.
- R5: An underflow with the action bit clear makes `irq` high for exactly the one cycle after the underflow edge.
- R6: A cycle with `act_set`=1 sets the action bit to reset. Driving `act_set` back to 0 does not clear the bit; only system reset clears it.
- R7: An underflow with the action bit set enters `WD_TRIPPED`. `rst_req` then goes high on the following cycle and stays high until system reset. No `irq` pulse is produced, `count` stays constant, and `refresh` is ignored.
- R8: Outside `WD_TRIPPED`, a `refresh` reloads the counter on that edge. The prescaler phases are left untouched.
- R9: A `refresh` on the same edge as an underflow tick wins: the counter reloads and no `irq` or reset request follows.
- R10: With `src_osc`=0, `freeze`=1 holds both the prescaler phase and the counter. Counting resumes from the held values when `freeze` returns to 0.
- R11: With `src_osc`=1, `freeze` has no effect on counting or on the period.
- R12: After a reset with `start_mode`=1, the counter and both prescalers stay still and no underflow occurs until the first `refresh`. That refresh starts counting from the reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| osc_tick | input | 1 | One-cycle enable per slow-oscillator period, synchronous to clk |
| refresh | input | 1 | Refresh write strobe |
| act_set | input | 1 | Sets the sticky reset-action bit |
| src_osc | input | 1 | Tick source: 0 system-clock prescaler, 1 oscillator prescaler |
| osc_div_sel | input | OSC_SEL_W | Oscillator divisor is 2^osc_div_sel |
| bus_div_sel | input | 1 | System-clock divisor: 0 gives 16, 1 gives 128 |
| start_mode | input | 1 | Sampled during reset: 1 waits for first refresh |
| freeze | input | 1 | Halt indication (wait, stop or hold) |
| irq | output | 1 | One-cycle underflow interrupt pulse |
| rst_req | output | 1 | Latched reset request |
| count | output | BUS_SPAN_W | Current counter value |

## Verification
The hardest case to reach from the ports is a refresh that lands on the very edge whose tick would underflow the counter. The bench drives the oscillator enable itself, so it knows in advance which edge carries a tick. It runs the oscillator path at divisor 1, polls `count` until it reads zero with a tick pending, and pulses `refresh` for exactly that edge. Freezes are also placed at known phases, so the resumed period can be predicted to the cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_RUN     = 2'd1,
        WD_TRIPPED = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdt_osc_prescale.sv
// Oscillator-path prescaler: free phase modulo 2^(2^SEL_W-1) pulses,
// tick on every pulse that completes a multiple of 2^div_sel.
module wdt_osc_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int PH_W = (1 << SEL_W) - 1;
    localparam logic [PH_W-1:0] PH_ONE = 1;

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] mask;

    for (genvar i = 0; i < PH_W; i++) begin : g_mask
        assign mask[i] = (int'(div_sel) > i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (adv) begin
            phase_q <= phase_q + PH_ONE;
        end
    end

    assign tick = adv && (&(phase_q | ~mask));

endmodule

// File: rtl/wdt_bus_prescale.sv
// System-clock prescaler: phase modulo 2^HI_LOG, divisor 2^LO_LOG or 2^HI_LOG.
module wdt_bus_prescale #(
    parameter int LO_LOG = 4,
    parameter int HI_LOG = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic div_sel,
    output logic tick
);
    localparam logic [HI_LOG-1:0] PH_ONE = 1;

    logic [HI_LOG-1:0] phase_q;
    logic [HI_LOG-1:0] mask;

    for (genvar i = 0; i < HI_LOG; i++) begin : g_mask
        if (i < LO_LOG) begin : g_low
            assign mask[i] = 1'b1;
        end else begin : g_high
            assign mask[i] = div_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (adv) begin
            phase_q <= phase_q + PH_ONE;
        end
    end

    assign tick = adv && (&(phase_q | ~mask));

endmodule

// File: rtl/wdt_down_counter.sv
// Loadable down counter; load has priority over decrement.
module wdt_down_counter #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         zero
);
    localparam logic [W-1:0] C_ONE = 1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= reload_val;
        end else if (load) begin
            cnt_q <= reload_val;
        end else if (dec) begin
            cnt_q <= cnt_q - C_ONE;
        end
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int BUS_SPAN_W = 15,
    parameter int OSC_SPAN_W = 11,
    parameter int OSC_SEL_W  = 2,
    parameter int BUS_LO_LOG = 4,
    parameter int BUS_HI_LOG = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  osc_tick,
    input  logic                  refresh,
    input  logic                  act_set,
    input  logic                  src_osc,
    input  logic [OSC_SEL_W-1:0]  osc_div_sel,
    input  logic                  bus_div_sel,
    input  logic                  start_mode,
    input  logic                  freeze,
    output logic                  irq,
    output logic                  rst_req,
    output logic [BUS_SPAN_W-1:0] count
);
    localparam int CNT_W = BUS_SPAN_W;
    localparam logic [CNT_W-1:0] BUS_RELOAD = '1;
    localparam logic [CNT_W-1:0] OSC_RELOAD =
        {{(CNT_W - OSC_SPAN_W){1'b0}}, {OSC_SPAN_W{1'b1}}};

    wd_state_e state_q, state_d;

    logic             act_q;
    logic             irq_q;
    logic             run_en;
    logic             bus_adv;
    logic             osc_adv;
    logic             bus_tick;
    logic             osc_div_tick;
    logic             cnt_tick;
    logic             cnt_zero;
    logic             refresh_ok;
    logic             underflow;
    logic             cnt_load;
    logic [CNT_W-1:0] reload_val;

    // State register; start mode is sampled while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= start_mode ? WD_IDLE : WD_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:    if (refresh) state_d = WD_RUN;
            WD_RUN:     if (underflow && act_q) state_d = WD_TRIPPED;
            WD_TRIPPED: state_d = WD_TRIPPED;
            default:    state_d = WD_IDLE;
        endcase
    end

    // State-decoded outputs and datapath controls.
    always_comb begin
        run_en     = (state_q == WD_RUN);
        rst_req    = (state_q == WD_TRIPPED);
        refresh_ok = refresh && (state_q != WD_TRIPPED);
        bus_adv    = run_en && !src_osc && !freeze;
        osc_adv    = run_en && osc_tick;
        cnt_tick   = src_osc ? osc_div_tick : bus_tick;
        underflow  = cnt_tick && cnt_zero && !refresh_ok;
        cnt_load   = refresh_ok || underflow;
        reload_val = src_osc ? OSC_RELOAD : BUS_RELOAD;
        irq        = irq_q;
    end

    // Sticky action bit and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            act_q <= act_q | act_set;
            irq_q <= underflow && !act_q;
        end
    end

    wdt_bus_prescale #(
        .LO_LOG (BUS_LO_LOG),
        .HI_LOG (BUS_HI_LOG)
    ) u_bus_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (bus_adv),
        .div_sel (bus_div_sel),
        .tick    (bus_tick)
    );

    wdt_osc_prescale #(
        .SEL_W (OSC_SEL_W)
    ) u_osc_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (osc_adv),
        .div_sel (osc_div_sel),
        .tick    (osc_div_tick)
    );

    wdt_down_counter #(
        .W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cnt_load),
        .dec        (cnt_tick),
        .reload_val (reload_val),
        .count      (count),
        .zero       (cnt_zero)
    );

endmodule

// File: rtl/wdt_core_checker.sv
module wdt_core_checker #(
    parameter int CNT_W      = 15,
    parameter int OSC_SPAN_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             src_osc,
    input logic             freeze,
    input logic             refresh,
    input logic             irq,
    input logic             rst_req,
    input logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] OSC_RL =
        {{(CNT_W - OSC_SPAN_W){1'b0}}, {OSC_SPAN_W{1'b1}}};

    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_rst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    assert_trip_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> ($stable(count) && !irq));

    assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_osc && freeze && !refresh && !rst_req) |=> $stable(count));

    assert_refresh_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && !rst_req) |=> (count == ($past(src_osc) ? OSC_RL : {CNT_W{1'b1}})));

    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> ((count == $past(count) - 1'b1) || (count == OSC_RL) || (&count)));

endmodule

bind wdt_core wdt_core_checker #(
    .CNT_W      (BUS_SPAN_W),
    .OSC_SPAN_W (OSC_SPAN_W)
) u_wdt_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_osc (src_osc),
    .freeze  (freeze),
    .refresh (refresh),
    .irq     (irq),
    .rst_req (rst_req),
    .count   (count)
);

// File: tb/test_wdt_core.sv
module test_wdt_core;
    localparam int BSW = 6;
    localparam int OSW = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           osc_tick = 1'b0;
    logic           refresh = 1'b0;
    logic           act_set = 1'b0;
    logic           src_osc = 1'b0;
    logic [1:0]     osc_div_sel = 2'd0;
    logic           bus_div_sel = 1'b0;
    logic           start_mode = 1'b0;
    logic           freeze = 1'b0;
    logic           irq;
    logic           rst_req;
    logic [BSW-1:0] count;

    int n_tests = 0;
    int n_fail  = 0;
    bit osc_en  = 1'b0;
    int osc_ph  = 0;
    bit chk_on  = 1'b0;

    wdt_core #(.BUS_SPAN_W(BSW), .OSC_SPAN_W(OSW)) i_wdt_core (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .refresh(refresh),
        .act_set(act_set), .src_osc(src_osc), .osc_div_sel(osc_div_sel),
        .bus_div_sel(bus_div_sel), .start_mode(start_mode), .freeze(freeze),
        .irq(irq), .rst_req(rst_req), .count(count)
    );

    function automatic int rl(bit s);
        return s ? (1 << OSW) - 1 : (1 << BSW) - 1;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Oscillator enable: one pulse every third clock.
    always @(negedge clk) begin
        #1;
        if (osc_en) begin
            osc_tick = (osc_ph == 0);
            osc_ph   = (osc_ph + 1) % 3;
        end else begin
            osc_tick = 1'b0;
        end
    end

    // Behavioural reference: state 0 idle, 1 run, 2 tripped.
    int m_state, m_cnt, m_bph, m_oph, m_irq;
    bit m_act;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = start_mode ? 0 : 1;
            m_cnt = rl(src_osc);
            m_bph = 0; m_oph = 0; m_act = 0; m_irq = 0;
        end else begin
            bit t;
            int nirq;
            t = 0; nirq = 0;
            if (m_state == 1 && !src_osc && !freeze) begin
                t = ((m_bph + 1) % (bus_div_sel ? 128 : 16)) == 0;
                m_bph = (m_bph + 1) % 128;
            end
            if (m_state == 1 && osc_tick) begin
                if (src_osc) t = ((m_oph + 1) % (1 << osc_div_sel)) == 0;
                m_oph = (m_oph + 1) % 8;
            end
            if (refresh && m_state != 2) begin
                m_cnt = rl(src_osc);
                if (m_state == 0) m_state = 1;
            end else if (t) begin
                if (m_cnt == 0) begin
                    m_cnt = rl(src_osc);
                    if (m_act) m_state = 2; else nirq = 1;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            m_act = m_act | act_set;
            m_irq = nirq;
        end
    end

    // Cycle-by-cycle comparison against the reference (R4, R5, R7).
    always @(negedge clk) begin
        if (chk_on) begin
            chk(int'(count) == m_cnt, "R4 model count", int'(count), m_cnt);
            chk(int'(irq) == m_irq, "R5 model irq", int'(irq), m_irq);
            chk(int'(rst_req) == int'(m_state == 2), "R7 model rst_req",
                int'(rst_req), int'(m_state == 2));
        end
    end

    task automatic edge_();
        @(negedge clk);
        #2;
    endtask

    task automatic do_reset(bit smode, bit src);
        rst_n = 1'b0; start_mode = smode; src_osc = src;
        refresh = 0; act_set = 0; freeze = 0;
        repeat (3) edge_();
        chk(int'(count) == rl(src), "R1 reset count", int'(count), rl(src));
        chk(!irq && !rst_req, "R1 reset outputs", int'({irq, rst_req}), 0);
        chk_on = 1'b1;
        rst_n = 1'b1;
    endtask

    task automatic wait_irq(output int cyc, input int limit);
        cyc = 0;
        do begin
            edge_();
            cyc++;
        end while (!irq && cyc < limit);
    endtask

    task automatic pulse_refresh();
        refresh = 1'b1;
        edge_();
        refresh = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c;
        int held;
        osc_en = 1'b1;

        // R1, R2: system-clock path, divide by 16, from reset.
        bus_div_sel = 0;
        do_reset(0, 0);
        wait_irq(c, 3000);
        chk(c == 1024, "R2 R1 div16 first period", c, 1024);
        wait_irq(c, 3000);
        chk(c == 1024, "R2 R5 div16 period", c, 1024);

        // R2: divide by 128.
        bus_div_sel = 1;
        wait_irq(c, 20000);
        wait_irq(c, 20000);
        chk(c == 8192, "R2 div128 period", c, 8192);

        // R3: oscillator path, all divisors.
        do_reset(0, 1);
        for (int d = 0; d < 4; d++) begin
            osc_div_sel = 2'(d);
            wait_irq(c, 2000);
            wait_irq(c, 2000);
            chk(c == 48 * (1 << d), "R3 osc period", c, 48 * (1 << d));
        end

        // R11: freeze ignored on oscillator path.
        osc_div_sel = 0;
        freeze = 1;
        wait_irq(c, 2000);
        wait_irq(c, 2000);
        chk(c == 48, "R11 osc period under freeze", c, 48);
        freeze = 0;

        // R8: periodic refresh prevents underflow.
        held = 0;
        pulse_refresh();
        for (int k = 0; k < 300; k++) begin
            edge_();
            if (irq) held++;
            if (k % 30 == 29) pulse_refresh();
        end
        chk(held == 0, "R8 refresh keeps alive", held, 0);

        // R9: refresh on the underflow edge wins.
        wait_irq(c, 2000);
        c = 0;
        while (!(count == '0 && osc_tick) && c < 200) begin
            edge_();
            c++;
        end
        refresh = 1'b1;
        edge_();
        refresh = 1'b0;
        chk(!irq, "R9 no irq on coincident refresh", int'(irq), 0);
        chk(int'(count) == rl(1), "R9 reload on coincident refresh", int'(count), rl(1));

        // R10: freeze on system-clock path holds and resumes.
        bus_div_sel = 0;
        do_reset(0, 0);
        repeat (200) edge_();
        freeze = 1;
        held = int'(count);
        repeat (400) edge_();
        chk(int'(count) == held, "R10 count held in freeze", int'(count), held);
        freeze = 0;
        wait_irq(c, 3000);
        chk(c == 824, "R10 resumed period", c, 824);

        // R6, R7: sticky reset action.
        act_set = 1; edge_(); act_set = 0;
        wait_irq(c, 3000);
        chk(c >= 3000, "R6 no irq with reset action", c, 3000);
        chk(rst_req, "R7 reset request raised", int'(rst_req), 1);
        held = int'(count);
        pulse_refresh();
        repeat (50) edge_();
        chk(rst_req, "R7 reset request held", int'(rst_req), 1);
        chk(int'(count) == held, "R7 refresh ignored when tripped", int'(count), held);

        // R12: start mode waits for first refresh; R6 cleared by reset.
        do_reset(1, 0);
        held = 0;
        for (int k = 0; k < 1500; k++) begin
            edge_();
            if (irq || int'(count) != rl(0)) held++;
        end
        chk(held == 0, "R12 stopped until refresh", held, 0);
        pulse_refresh();
        wait_irq(c, 3000);
        chk(c == 1024, "R12 period after first refresh", c, 1024);
        chk(!rst_req, "R6 action cleared by reset", int'(rst_req), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule